// File: doc/BRIEF.md
# Forwarding Register-Add Pipeline

This block executes a stream of register-to-register additions with two pipeline stages. Each cycle, the issue port may present one operation that names a destination register and two source registers. In the first stage, the block gathers both operands and computes their sum with wrap-around arithmetic, then places it in a held execute/writeback register together with the operation's destination. In the second stage, the block writes that held result into the register file.

Both stages are active in the same cycle, so a newly issued operation may read the register that the operation ahead of it is about to write. The block never stalls. It detects the match on either source and routes the held result straight into the new sum, while the same held result is written back in parallel. A valid flag travels with the held register, and no writeback or forwarding happens while that flag is clear.

A preload port puts initial values into the register file, so that the pipeline has non-zero data to work on. Each writeback is also presented on output ports, so that the committed stream can be compared with a sequential model.

Top module: `addp_pipe`

## Requirements
- R1: After reset, `wb_en` is low, and every register reads as zero to the first operation issued.
- R2: The committed value is the sum of the two source registers modulo 2^DATA_W, taken in program order. For example, 16'hFFF0 + 16'h0020 commits 16'h0010.
- R3: An operation accepted with `op_valid` high in cycle k appears in cycle k+1 with `wb_en` high, `wb_idx` equal to its destination and `wb_data` equal to its result. The register is written at the end of cycle k+1.
- R4: If the held destination matches neither source of the incoming operation, both operands come from the register file.
- R5: If the held destination equals the first source only, the first operand is the held result.
- R6: If the held destination equals the second source only, the second operand is the held result.
- R7: If the held destination equals both sources, both operands are the held result.
- R8: A cycle with `op_valid` low produces no writeback in the next cycle. An operation issued after such a bubble reads from the register file and is never given a stale held result.
- R9: A held result that is forwarded is also written to its destination in that same cycle. Later readers find it in the register file.
- R10: `ld_en` writes `ld_data` into register `ld_idx` at the end of the cycle. An operation issued in that same cycle still reads the old value.
- R11: If a writeback and a preload hit the same register in one cycle, the writeback wins. If they hit different registers, both are written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | An operation is issued this cycle |
| op_dst | input | IDX_W | Destination register index |
| op_src_a | input | IDX_W | First source register index |
| op_src_b | input | IDX_W | Second source register index |
| ld_en | input | 1 | Preload strobe |
| ld_idx | input | IDX_W | Preload register index |
| ld_data | input | DATA_W | Preload value |
| wb_en | output | 1 | A writeback commits this cycle |
| wb_idx | output | IDX_W | Register being written back |
| wb_data | output | DATA_W | Value being written back |

## Verification
Forwarding and writeback of the same held result fall in the same cycle whenever one operation reads the destination of the operation issued just before it. The bench provokes this by issuing operations back to back that hit the first source, the second source or both. It judges each committed write against a sequential model that applies the operations one at a time, and it reads the forwarded register again after a bubble to show that the write landed. Preloads are also placed in the cycle of a writeback to the same register and in the cycle of a read of that register, so that the ordering rules for those collisions are exercised.

// File: rtl/addp_pkg.sv
package addp_pkg;
  // Where an operand was taken from in the execute stage
  typedef enum logic {
    OPND_FROM_RF   = 1'b0,
    OPND_FROM_HELD = 1'b1
  } opnd_src_e;
endpackage

// File: rtl/addp_regfile.sv
module addp_regfile #(
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 16,
  parameter int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_a_idx,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [IDX_W-1:0]  rd_b_idx,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic              wb_en,
  input  logic [IDX_W-1:0]  wb_idx,
  input  logic [DATA_W-1:0] wb_data,
  input  logic              ld_en,
  input  logic [IDX_W-1:0]  ld_idx,
  input  logic [DATA_W-1:0] ld_data
);
  logic [DATA_W-1:0] regs [NUM_REGS];

  // One storage slot per register; writeback has priority over preload (R11)
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_slot
    logic hit_wb, hit_ld;
    assign hit_wb = wb_en && (wb_idx == IDX_W'(g));
    assign hit_ld = ld_en && (ld_idx == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (!rst_n)      regs[g] <= '0;
      else if (hit_wb) regs[g] <= wb_data;
      else if (hit_ld) regs[g] <= ld_data;
    end
  end

  assign rd_a_data = regs[rd_a_idx];
  assign rd_b_data = regs[rd_b_idx];

  // R9: a writeback is visible in the array one cycle later
  a_r9_wb_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |=> regs[$past(wb_idx)] == $past(wb_data));

  // R11: a preload that does not collide with a writeback lands
  a_r11_ld_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && !(wb_en && wb_idx == ld_idx)) |=> regs[$past(ld_idx)] == $past(ld_data));
endmodule

// File: rtl/addp_opnd_sel.sv
module addp_opnd_sel
  import addp_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 3
) (
  input  logic              held_valid,
  input  logic [IDX_W-1:0]  held_dst,
  input  logic [DATA_W-1:0] held_result,
  input  logic [IDX_W-1:0]  src_idx,
  input  logic [DATA_W-1:0] rf_data,
  output logic [DATA_W-1:0] opnd,
  output opnd_src_e         src_sel
);
  always_comb begin
    src_sel = (held_valid && (held_dst == src_idx)) ? OPND_FROM_HELD : OPND_FROM_RF;
    opnd    = (src_sel == OPND_FROM_HELD) ? held_result : rf_data;
  end
endmodule

// File: rtl/addp_exwb.sv
module addp_exwb #(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_valid,
  input  logic [IDX_W-1:0]  issue_dst,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  output logic              held_valid,
  output logic [IDX_W-1:0]  held_dst,
  output logic [DATA_W-1:0] held_result
);
  // Wrap-around addition of two operands (R2)
  function automatic logic [DATA_W-1:0] wrap_sum(input logic [DATA_W-1:0] x,
                                                 input logic [DATA_W-1:0] y);
    return x + y;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_valid  <= 1'b0;
      held_dst    <= '0;
      held_result <= '0;
    end else begin
      held_valid <= issue_valid;
      if (issue_valid) begin
        held_dst    <= issue_dst;
        held_result <= wrap_sum(opnd_a, opnd_b);
      end
    end
  end

  // R3: an issued operation is held next cycle with its destination
  a_r3_issue_held: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |=> (held_valid && held_dst == $past(issue_dst)));

  // R8: a bubble leaves nothing valid behind
  a_r8_bubble_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_valid |=> !held_valid);
endmodule

// File: rtl/addp_pipe.sv
module addp_pipe
  import addp_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 16,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [IDX_W-1:0]  op_dst,
  input  logic [IDX_W-1:0]  op_src_a,
  input  logic [IDX_W-1:0]  op_src_b,
  input  logic              ld_en,
  input  logic [IDX_W-1:0]  ld_idx,
  input  logic [DATA_W-1:0] ld_data,
  output logic              wb_en,
  output logic [IDX_W-1:0]  wb_idx,
  output logic [DATA_W-1:0] wb_data
);
  localparam int NUM_SRC = 2;

  logic              held_valid;
  logic [IDX_W-1:0]  held_dst;
  logic [DATA_W-1:0] held_result;

  logic [IDX_W-1:0]  src_idx [NUM_SRC];
  logic [DATA_W-1:0] rf_rd   [NUM_SRC];
  logic [DATA_W-1:0] opnd    [NUM_SRC];
  opnd_src_e         opnd_sel[NUM_SRC];

  assign src_idx[0] = op_src_a;
  assign src_idx[1] = op_src_b;

  // Writeback stage: driven straight from the held register
  assign wb_en   = held_valid;
  assign wb_idx  = held_dst;
  assign wb_data = held_result;

  addp_regfile #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .IDX_W(IDX_W)) rf_i (
    .clk(clk), .rst_n(rst_n),
    .rd_a_idx(src_idx[0]), .rd_a_data(rf_rd[0]),
    .rd_b_idx(src_idx[1]), .rd_b_data(rf_rd[1]),
    .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data),
    .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(ld_data)
  );

  // One operand selector per source port
  for (genvar p = 0; p < NUM_SRC; p++) begin : g_src
    addp_opnd_sel #(.DATA_W(DATA_W), .IDX_W(IDX_W)) sel_i (
      .held_valid(held_valid), .held_dst(held_dst), .held_result(held_result),
      .src_idx(src_idx[p]), .rf_data(rf_rd[p]),
      .opnd(opnd[p]), .src_sel(opnd_sel[p])
    );
  end

  addp_exwb #(.DATA_W(DATA_W), .IDX_W(IDX_W)) exwb_i (
    .clk(clk), .rst_n(rst_n),
    .issue_valid(op_valid), .issue_dst(op_dst),
    .opnd_a(opnd[0]), .opnd_b(opnd[1]),
    .held_valid(held_valid), .held_dst(held_dst), .held_result(held_result)
  );

  // Named hazard events for the assertions
  logic hz_a, hz_b;
  assign hz_a = op_valid && held_valid && (held_dst == op_src_a);
  assign hz_b = op_valid && held_valid && (held_dst == op_src_b);

  // R4: no match, both operands from the register file
  a_r4_no_hazard: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !hz_a && !hz_b) |=>
      held_result == DATA_W'($past(rf_rd[0]) + $past(rf_rd[1])));

  // R5: first source forwarded from the held result
  a_r5_fwd_first: assert property (@(posedge clk) disable iff (!rst_n)
    (hz_a && !hz_b) |=> held_result == DATA_W'($past(held_result) + $past(rf_rd[1])));

  // R6: second source forwarded from the held result
  a_r6_fwd_second: assert property (@(posedge clk) disable iff (!rst_n)
    (hz_b && !hz_a) |=> held_result == DATA_W'($past(rf_rd[0]) + $past(held_result)));

  // R7: both sources forwarded
  a_r7_fwd_both: assert property (@(posedge clk) disable iff (!rst_n)
    (hz_a && hz_b) |=> held_result == DATA_W'($past(held_result) + $past(held_result)));

  // R1: nothing commits in the first cycle after reset
  a_r1_idle_after_reset: assert property (@(posedge clk)
    !rst_n |=> !wb_en);
endmodule

// File: tb/addp_pipe_tb_top.sv
`timescale 1ns/1ps
module addp_pipe_tb_top;
  localparam int NR = 8;
  localparam int DW = 16;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          op_valid = 1'b0;
  logic [IW-1:0] op_dst = '0, op_src_a = '0, op_src_b = '0;
  logic          ld_en = 1'b0;
  logic [IW-1:0] ld_idx = '0;
  logic [DW-1:0] ld_data = '0;
  logic          wb_en;
  logic [IW-1:0] wb_idx;
  logic [DW-1:0] wb_data;

  int n_checks = 0;
  int n_fails  = 0;

  // Sequential reference: operations applied one at a time in program order
  logic [DW-1:0] ref_rf [NR];
  bit            pend_v = 1'b0;
  int            pend_d = 0;
  logic [DW-1:0] pend_val = '0;
  string         pend_tag = "";

  always #2 clk = ~clk;

  addp_pipe #(.NUM_REGS(NR), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .op_valid(op_valid), .op_dst(op_dst), .op_src_a(op_src_a), .op_src_b(op_src_b),
    .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(ld_data),
    .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data)
  );

  // Compare this cycle's writeback outputs with the pending expected commit
  task automatic check_commit();
    n_checks++;
    if (wb_en !== pend_v) begin
      n_fails++;
      $display("FAIL %s: wb_en actual %0b expected %0b", pend_tag, wb_en, pend_v);
    end else if (pend_v && (wb_idx !== IW'(pend_d) || wb_data !== pend_val)) begin
      n_fails++;
      $display("FAIL %s: commit actual r%0d=%h expected r%0d=%h",
               pend_tag, wb_idx, wb_data, pend_d, pend_val);
    end
  endtask

  // One cycle: check the previous commit, then drive an op and/or a preload
  task automatic step(input bit ov, input int d, input int a, input int b,
                      input bit lv, input int li, input logic [DW-1:0] ld,
                      input string tag);
    logic [DW-1:0] e;
    @(negedge clk);
    check_commit();
    op_valid = ov; op_dst = IW'(d); op_src_a = IW'(a); op_src_b = IW'(b);
    ld_en = lv; ld_idx = IW'(li); ld_data = ld;
    e = ref_rf[a] + ref_rf[b];                       // reads precede this cycle's preload (R10)
    if (lv && !(pend_v && pend_d == li)) ref_rf[li] = ld;  // writeback wins (R11)
    if (ov) ref_rf[d] = e;
    pend_v = ov; pend_d = d; pend_val = e; pend_tag = tag;
  endtask

  task automatic op(input int d, input int a, input int b, input string tag);
    step(1'b1, d, a, b, 1'b0, 0, '0, tag);
  endtask
  task automatic idle(input string tag);
    step(1'b0, 0, 0, 0, 1'b0, 0, '0, tag);
  endtask
  task automatic load(input int li, input logic [DW-1:0] v, input string tag);
    step(1'b0, 0, 0, 0, 1'b1, li, v, tag);
  endtask

  task automatic t_reset();
    n_checks++;
    if (wb_en !== 1'b0) begin
      n_fails++;
      $display("FAIL R1: wb_en after reset actual %0b expected 0", wb_en);
    end
    op(1, 2, 3, "R1_zero_regs");   // every register reads zero
    op(4, 5, 6, "R1_zero_regs");
    idle("R3");
  endtask

  task automatic t_no_hazard();
    load(1, 16'd5, "R10"); load(2, 16'd7, "R10");
    load(4, 16'hFFF0, "R10"); load(5, 16'h0020, "R10");
    op(3, 1, 2, "R4_from_rf");
    op(6, 4, 5, "R2_wrap");        // expects 16'h0010
    idle("R3");
  endtask

  task automatic t_forward();
    op(3, 1, 2, "R3"); op(7, 3, 1, "R5_fwd_first"); idle("R5_fwd_first");
    op(3, 2, 1, "R3"); op(0, 2, 3, "R6_fwd_second"); idle("R6_fwd_second");
    op(2, 1, 1, "R3"); op(5, 2, 2, "R7_fwd_both"); idle("R7_fwd_both");
  endtask

  task automatic t_writeback_parallel();
    op(3, 1, 2, "R9"); op(4, 3, 3, "R9_fwd_and_wb");
    idle("R9"); op(6, 3, 4, "R9_read_after_wb"); idle("R9");
  endtask

  task automatic t_bubble();
    op(3, 1, 1, "R8");
    idle("R8_no_commit");
    load(3, 16'd100, "R8");
    op(5, 3, 3, "R8_no_stale_fwd");   // must see 100+100
    idle("R8");
  endtask

  task automatic t_load_ordering();
    load(2, 16'd11, "R10");
    step(1'b1, 6, 2, 2, 1'b1, 2, 16'd40, "R10_old_value");  // reads 11
    op(7, 2, 2, "R10_new_value");                          // reads 40
    idle("R10");
    op(6, 1, 2, "R11");
    step(1'b0, 0, 0, 0, 1'b1, 6, 16'h1234, "R11_wb_wins");
    op(7, 6, 6, "R11_wb_wins");
    op(1, 2, 2, "R11");
    step(1'b0, 0, 0, 0, 1'b1, 4, 16'h0303, "R11_both_written");
    op(5, 1, 4, "R11_both_written");
    idle("R11");
  endtask

  task automatic t_stream();
    for (int i = 0; i < 300; i++) begin
      int r;
      r = int'($urandom_range(9, 0));
      if (r == 0) idle("R8_stream");
      else if (r == 1)
        step(1'b0, 0, 0, 0, 1'b1, int'($urandom_range(NR-1, 0)), DW'($urandom), "R10_stream");
      else if (r == 2)
        step(1'b1, int'($urandom_range(NR-1, 0)), int'($urandom_range(NR-1, 0)),
             int'($urandom_range(NR-1, 0)), 1'b1, int'($urandom_range(NR-1, 0)),
             DW'($urandom), "R11_stream");
      else
        op(int'($urandom_range(NR-1, 0)), int'($urandom_range(NR-1, 0)),
           int'($urandom_range(NR-1, 0)), "R2_stream");
    end
    idle("R2_stream");
    idle("R8_stream");
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < NR; i++) ref_rf[i] = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_no_hazard();
    t_forward();
    t_writeback_parallel();
    t_bubble();
    t_load_ordering();
    t_stream();
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end
endmodule